// File: doc/BRIEF.md
# Latched Multiplexed Seven-Segment Scanner

This block sits between a four-decade BCD counter and a common-segment four-digit display. It keeps a copy of the counter value in an output latch. While the latch-enable input is high the latch is transparent and follows the counter. While it is low the latch holds the last value it took. A source-select input picks what is shown: the live counter digits or the latched digits.

The display is time multiplexed. A free-running scan timer, derived from the system clock through a parameterized divider, steps through the four digit positions at about 1 kHz per slot by default. No separate scan clock is needed. Each slot lights one digit strobe and drives the seven segment lines with the decoded pattern of that digit. The first cycle of every slot is blank, which keeps segment data from ghosting onto a neighbouring digit.

Top module: `seg_scan_top`

## Requirements
- R1: While rst_ni is low, dig_o and seg_o are all zero and the held latch value is cleared to zero. After reset the first digit lit is digit 0 (dig_o = 4'b0001). With latch_en_i and show_live_i low, every digit then shows the pattern for 0.
- R2: dig_o is always zero or one-hot. Bit k strobes digit k, which takes its value from bits [4k+3:4k] of the source. Lit strobes follow the order 0, 1, 2, 3 and then wrap back to 0.
- R3: Each digit slot lasts DIV = CLK_HZ/SCAN_HZ clock cycles. Its first cycle is blank (dig_o = 0, seg_o = 0), and its strobe stays lit for the remaining DIV-1 cycles.
- R4: seg_o is active high, with bit 0 = a through bit 6 = g. The codes 0 through 9 give 7'h3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F.
- R5: A digit holding a code from 10 to 15 shows seg_o = 0 while its strobe is lit.
- R6: When latch_en_i is high the latch is transparent. With show_live_i low, the display follows cnt_digits_i.
- R7: When latch_en_i is low the latch holds the value it had on the last clock edge with latch_en_i high. Later changes of cnt_digits_i do not reach a display that has show_live_i low.
- R8: When show_live_i is high the display shows cnt_digits_i directly, whatever the latch holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; also the source of the scan timer |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_digits_i | input | 16 | Four BCD digits from the counter, digit 0 in bits [3:0] |
| latch_en_i | input | 1 | 1 = latch transparent, 0 = latch holds |
| show_live_i | input | 1 | 1 = show counter digits, 0 = show latched digits |
| seg_o | output | 7 | Segment lines, active high, bit 0 = a through bit 6 = g |
| dig_o | output | 4 | One-hot digit strobes, bit k = digit k |

## Verification
The bench builds the block with CLK_HZ = 8000 and SCAN_HZ = 1000, so each slot is 8 cycles long. At that size a whole scan round takes 32 cycles, and a run of several rounds fits in a few hundred cycles. This makes it possible to check the exact slot length, the single blank cycle and the wrap from digit 3 back to digit 0 many times over. It also leaves time to show the hold and transparent latch behaviour, and the source select, on every digit position.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int SEG_W = 7;

  // bit 0 = a ... bit 6 = g, active high; 10..15 blank
  function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [3:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/scan_hold_latch.sv
module scan_hold_latch #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;
  logic         past_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      past_vld_q <= 1'b0;
    end else begin
      past_vld_q <= 1'b1;
      if (le_i) hold_q <= d_i;
    end
  end

  // flow-through while enabled
  assign q_o = le_i ? d_i : hold_q;

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && !$past(le_i)) |-> (hold_q == $past(hold_q))); // R7
  AST_LATCH_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && $past(le_i)) |-> (hold_q == $past(d_i))); // R6
endmodule

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int DIV      = 8,
  parameter int N        = 4,
  localparam int CNT_W   = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] idx_o,
  output logic             blank_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
      idx_q <= (idx_q == IDX_W'(N - 1)) ? '0 : idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idx_o   = idx_q;
  assign blank_o = (cnt_q == '0);

  AST_SWITCH_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q != $past(idx_q)) |-> blank_o); // R3
  AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q != $past(idx_q)) |->
      (idx_q == (($past(idx_q) == IDX_W'(N - 1)) ? '0 : $past(idx_q) + 1'b1))); // R2
endmodule

// File: rtl/seg_drive.sv
module seg_drive
  import scan_pkg::*;
#(
  parameter int N       = 4,
  parameter int DW      = 4,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N*DW-1:0]  digits_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             blank_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [N-1:0]     dig_o
);
  logic [DW-1:0] dig_arr [N];
  logic [DW-1:0] cur;

  for (genvar k = 0; k < N; k++) begin : g_split
    assign dig_arr[k] = digits_i[k*DW +: DW];
  end

  assign cur   = dig_arr[idx_i];
  assign dig_o = blank_i ? '0 : (N'(1) << idx_i);
  assign seg_o = blank_i ? '0 : bcd_to_seg(4'(cur));

  AST_STROBE_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dig_o)); // R2
  AST_BAD_CODE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dig_o != '0) && (cur > DW'(9))) |-> (seg_o == '0)); // R5
endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int BCD_W      = 4,
  parameter int CLK_HZ     = 250_000_000,
  parameter int SCAN_HZ    = 1000,
  localparam int DIV       = CLK_HZ / SCAN_HZ,
  localparam int SRC_W     = NUM_DIGITS * BCD_W,
  localparam int IDX_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SRC_W-1:0]      cnt_digits_i,
  input  logic                  latch_en_i,
  input  logic                  show_live_i,
  output logic [SEG_W-1:0]      seg_o,
  output logic [NUM_DIGITS-1:0] dig_o
);
  logic [SRC_W-1:0] latched;
  logic [SRC_W-1:0] src;
  logic [IDX_W-1:0] idx;
  logic             blank;

  scan_hold_latch #(.W(SRC_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .le_i  (latch_en_i),
    .d_i   (cnt_digits_i),
    .q_o   (latched)
  );

  assign src = show_live_i ? cnt_digits_i : latched;

  scan_timer #(.DIV(DIV), .N(NUM_DIGITS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_o  (idx),
    .blank_o(blank)
  );

  seg_drive #(.N(NUM_DIGITS), .DW(BCD_W)) u_drive (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .digits_i(src),
    .idx_i   (idx),
    .blank_i (blank),
    .seg_o   (seg_o),
    .dig_o   (dig_o)
  );

  AST_RESET_DARK: assert property (@(posedge clk_i)
    !rst_ni |-> (dig_o == '0 && seg_o == '0)); // R1
endmodule

// File: tb/seg_scan_top_tb.sv
`timescale 1ns/1ps
module seg_scan_top_tb;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cnt_digits = 16'h1234;
  logic        latch_en = 1'b0;
  logic        show_live = 1'b0;
  logic [6:0]  seg;
  logic [3:0]  dig;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_scan_top #(.CLK_HZ(8000), .SCAN_HZ(1000)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cnt_digits_i(cnt_digits),
    .latch_en_i  (latch_en),
    .show_live_i (show_live),
    .seg_o       (seg),
    .dig_o       (dig)
  );

  function automatic logic [6:0] ref_seg(input logic [3:0] v);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (v > 4'd9) ? 7'h00 : t[v];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // wait until digit k is lit, then compare its segments
  task automatic see_digit(input string req, input int k, input logic [3:0] v);
    bit hit = 1'b0;
    for (int i = 0; i < 4*DIV + 4 && !hit; i++) begin
      @(negedge clk);
      if (dig == 4'(1 << k)) hit = 1'b1;
    end
    check({req, " strobe"}, {28'd0, dig}, 32'(1 << k));
    check({req, " segs"}, {25'd0, seg}, {25'd0, ref_seg(v)});
  endtask

  task automatic see_all(input string req, input logic [15:0] val);
    for (int k = 0; k < 4; k++) see_digit(req, k, val[4*k +: 4]);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 dig in reset", {28'd0, dig}, 32'd0);
    check("R1 seg in reset", {25'd0, seg}, 32'd0);
    rst_ni = 1'b1;
    begin
      logic [3:0] first = 4'd0;
      for (int i = 0; i < 4*DIV && first == 4'd0; i++) begin
        @(negedge clk);
        first = dig;
      end
      check("R1 first digit", {28'd0, first}, 32'd1);
    end
    see_all("R1 cleared latch", 16'h0000);
  endtask

  task automatic t_order();
    logic [3:0] prev, last;
    int zrun, lrun;
    bit seen;
    @(negedge clk);
    while (dig != 4'd0) @(negedge clk);
    prev = 4'd0; zrun = 0; lrun = 0; seen = 1'b0; last = 4'd0;
    for (int i = 0; i < 6*4*DIV; i++) begin
      if (dig == 4'd0) begin
        if (prev != 4'd0) check("R3 lit length", lrun, DIV - 1);
        check("R3 seg dark in gap", {25'd0, seg}, 32'd0);
        zrun++;
      end else begin
        if (prev == 4'd0) begin
          check("R3 gap length", zrun, 1);
          if (seen) check("R2 strobe order", {28'd0, dig}, {28'd0, last[2:0], last[3]});
          seen = 1'b1;
          last = dig;
          lrun = 0;
          zrun = 0;
        end
        lrun++;
      end
      prev = dig;
      @(negedge clk);
    end
  endtask

  task automatic t_decode();
    show_live = 1'b1;
    cnt_digits = 16'h3210; see_all("R4 codes 0-3", cnt_digits);
    cnt_digits = 16'h7654; see_all("R4 codes 4-7", cnt_digits);
    cnt_digits = 16'h0989; see_all("R4 codes 8-9", cnt_digits);
  endtask

  task automatic t_blank();
    show_live = 1'b1;
    cnt_digits = 16'hDCBA; see_all("R5 codes A-D dark", cnt_digits);
    cnt_digits = 16'h5FE9; see_all("R5 codes E-F dark", cnt_digits);
  endtask

  task automatic t_latch();
    @(negedge clk);
    show_live = 1'b0;
    latch_en = 1'b1;
    cnt_digits = 16'h5678;
    see_all("R6 transparent", 16'h5678);
    cnt_digits = 16'h4321;
    see_all("R6 transparent follow", 16'h4321);
    @(negedge clk);
    latch_en = 1'b0;
    cnt_digits = 16'h9012;
    see_all("R7 hold", 16'h4321);
    cnt_digits = 16'h8888;
    see_all("R7 hold again", 16'h4321);
    show_live = 1'b1;
    see_all("R8 live over latch", 16'h8888);
    show_live = 1'b0;
    see_all("R7 held after live", 16'h4321);
  endtask

  initial begin
    t_reset();
    t_order();
    t_decode();
    t_blank();
    t_latch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule